// File: doc/BRIEF.md
# Pre-Bias Synchronous Rectifier Ramp-In Controller

This block decides when the low-side rectifier switch of a synchronous buck stage may conduct while the converter soft-starts into an output that already carries a voltage. A fixed on-time rectifier would pull current out of such an output. The block therefore keeps the rectifier dark until the high-side switch has issued its first pulse of the current soft start. It then releases the rectifier in small steps. Each low-side pulse ends exactly when the next period begins. Its leading edge moves earlier from one period to the next until it reaches the high-side falling edge, which gives fully complementary switching.

A period is `PERIOD_TICKS` clock ticks long, and a strobe from the period generator marks its first tick. The ramp covers `RAMP_CYCLES` periods. The first of these is the period in which the first high-side pulse appears. After the ramp, the rectifier is simply the complement of the high-side drive, in every period, so the stage can both source and sink current. Any period without a high-side pulse during the ramp also goes without a rectifier pulse. Dead-time insertion and the analog control loop sit outside this block.

Top module: `sr_rampin`

## Requirements
- R1: While `rst` is high and on the first tick after it, the block is in the waiting state and `ls_en` is 0.
- R2: From the start of a soft start until the first tick on which `hs_drive` is high, `ls_en` stays 0 on every tick, including periods with no high-side pulse at all.
- R3: In the period that holds the first high-side pulse of a soft start, `ls_en` is high on the last tick of the period (tick `PERIOD_TICKS`-1) and on no other tick, provided `hs_drive` has fallen by then.
- R4: During the ramp, the allowed rectifier width starts at 1 tick. It grows by STEP = ceil(`PERIOD_TICKS`/`RAMP_CYCLES`) ticks at each period boundary that follows a period with a high-side pulse, and it saturates at `PERIOD_TICKS`. The observed on-time in a ramp period with high time H is min(width, `PERIOD_TICKS` - H).
- R5: During the ramp, `ls_en` is high exactly on ticks t with t >= H and t >= `PERIOD_TICKS` - width. Tick 0, marked by `period_start`, is always low, so each pulse ends at the start of the next period.
- R6: During the ramp, a period in which `hs_drive` never goes high has `ls_en` low on all ticks, and the width does not grow at its end.
- R7: The ramp lasts `RAMP_CYCLES` periods, counting the first one. From the tick after the next period boundary onward, `ls_en` equals the inverse of `hs_drive` on every tick, and it stays high for a whole period that has no high-side pulse.
- R8: `ls_en` is never high on a tick where `hs_drive` is high.
- R9: A rising edge of `ss_active` returns the block to the waiting state and clears the ramp cycle count. From the next tick onward, `ls_en` behaves as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ss_active | input | 1 | High while a soft start is in progress; a rising edge starts a new ramp-in |
| period_start | input | 1 | High on tick 0 of each switching period |
| hs_drive | input | 1 | High-side drive signal, high while the main switch is on |
| ls_en | output | 1 | Low-side rectifier enable |

## Verification
Assertions check on every cycle that the rectifier never overlaps the high-side drive, that the waiting state keeps it dark, and that a new soft start resets the state. They also check that the width grows by exactly one step after a pulsed period and holds after a skipped one, that the cycle count moves only at period boundaries, and that the output is the complement of the high-side drive after the ramp. Only the bench's scenarios show the placement of each pulse within its period against a period-level model. These scenarios cover a ramp interleaved with skipped periods through to the full complementary mode, and a restart out of the full mode. In the restart, a wide high-side pulse leaves an off-time shorter than the allowed width, so the cap on the on-time is exercised.

// File: rtl/sr_rampin_pkg.sv
package sr_rampin_pkg;

    typedef enum logic [1:0] {
        MODE_WAIT = 2'd0,
        MODE_RAMP = 2'd1,
        MODE_FULL = 2'd2
    } ramp_mode_e;

    typedef struct packed {
        ramp_mode_e mode;
        logic       ss_seen;
    } ctrl_state_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sr_period_timer.sv
module sr_period_timer #(
    parameter int unsigned PERIOD_TICKS = 32,
    parameter int unsigned TICK_W       = $clog2(PERIOD_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_start,
    input  logic              hs_drive,
    output logic [TICK_W-1:0] tick_cur,
    output logic              seen_cur,
    output logic              seen_run
);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(PERIOD_TICKS - 1);

    logic [TICK_W-1:0] tick_q;
    logic              seen_q;

    always_comb begin
        tick_cur = period_start ? '0 : tick_q;
        seen_cur = period_start ? 1'b0 : seen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (tick_cur < TICK_LAST)
                tick_q <= tick_cur + TICK_W'(1);
            else
                tick_q <= tick_cur;
            seen_q <= seen_cur | hs_drive;
        end
    end

    assign seen_run = seen_q;
endmodule

// File: rtl/sr_ramp_ctrl.sv
module sr_ramp_ctrl
    import sr_rampin_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 32,
    parameter int unsigned RAMP_CYCLES  = 128,
    parameter int unsigned TICK_W       = $clog2(PERIOD_TICKS + 1),
    parameter int unsigned CNT_W        = $clog2(RAMP_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_active,
    input  logic              hs_drive,
    input  logic              period_start,
    input  logic              seen_run,
    output ramp_mode_e        mode,
    output logic [CNT_W-1:0]  cnt,
    output logic [TICK_W-1:0] width
);
    localparam int unsigned      STEP     = ceil_div(PERIOD_TICKS, RAMP_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RAMP_CYCLES - 1);
    localparam logic [TICK_W:0]  FULL_W   = (TICK_W + 1)'(PERIOD_TICKS);

    ctrl_state_t       st_q, st_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [TICK_W-1:0] width_q, width_n;
    logic [TICK_W:0]   w_sum;
    logic [TICK_W-1:0] w_grow;
    logic              ss_rise;

    always_comb begin
        w_sum  = {1'b0, width_q} + (TICK_W + 1)'(STEP);
        w_grow = (w_sum >= FULL_W) ? FULL_W[TICK_W-1:0] : w_sum[TICK_W-1:0];
    end

    assign ss_rise = ss_active & ~st_q.ss_seen;

    always_comb begin
        st_n         = st_q;
        st_n.ss_seen = ss_active;
        cnt_n        = cnt_q;
        width_n      = width_q;
        if (ss_rise) begin
            st_n.mode = MODE_WAIT;
            cnt_n     = '0;
            width_n   = TICK_W'(1);
        end else begin
            unique case (st_q.mode)
                MODE_WAIT: begin
                    if (hs_drive) begin
                        st_n.mode = MODE_RAMP;
                        cnt_n     = '0;
                        width_n   = TICK_W'(1);
                    end
                end
                MODE_RAMP: begin
                    if (period_start) begin
                        if (cnt_q == CNT_LAST) begin
                            st_n.mode = MODE_FULL;
                        end else begin
                            cnt_n = cnt_q + CNT_W'(1);
                            if (seen_run)
                                width_n = w_grow;
                        end
                    end
                end
                default: begin
                    st_n.mode = MODE_FULL;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '{mode: MODE_WAIT, ss_seen: 1'b0};
            cnt_q   <= '0;
            width_q <= TICK_W'(1);
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            width_q <= width_n;
        end
    end

    assign mode  = st_q.mode;
    assign cnt   = cnt_q;
    assign width = width_q;
endmodule

// File: rtl/sr_ls_gate.sv
module sr_ls_gate
    import sr_rampin_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 32,
    parameter int unsigned TICK_W       = $clog2(PERIOD_TICKS + 1)
) (
    input  ramp_mode_e        mode,
    input  logic [TICK_W-1:0] tick_cur,
    input  logic [TICK_W-1:0] width,
    input  logic              seen_cur,
    input  logic              hs_drive,
    output logic              ls_en
);
    logic [TICK_W:0] win_start;
    logic            in_win;

    always_comb begin
        win_start = (TICK_W + 1)'(PERIOD_TICKS) - {1'b0, width};
        in_win    = {1'b0, tick_cur} >= win_start;
        unique case (mode)
            MODE_RAMP: ls_en = seen_cur & ~hs_drive & in_win;
            MODE_FULL: ls_en = ~hs_drive;
            default:   ls_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/sr_rampin.sv
module sr_rampin
    import sr_rampin_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 32,
    parameter int unsigned RAMP_CYCLES  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic ss_active,
    input  logic period_start,
    input  logic hs_drive,
    output logic ls_en
);
    localparam int unsigned TICK_W = $clog2(PERIOD_TICKS + 1);
    localparam int unsigned CNT_W  = (RAMP_CYCLES > 1) ? $clog2(RAMP_CYCLES) : 1;

    logic [TICK_W-1:0] tick_cur;
    logic              seen_cur;
    logic              seen_run;
    ramp_mode_e        mode;
    logic [CNT_W-1:0]  cnt;
    logic [TICK_W-1:0] width;

    sr_period_timer #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .TICK_W      (TICK_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .period_start(period_start),
        .hs_drive    (hs_drive),
        .tick_cur    (tick_cur),
        .seen_cur    (seen_cur),
        .seen_run    (seen_run)
    );

    sr_ramp_ctrl #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .RAMP_CYCLES (RAMP_CYCLES),
        .TICK_W      (TICK_W),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ss_active   (ss_active),
        .hs_drive    (hs_drive),
        .period_start(period_start),
        .seen_run    (seen_run),
        .mode        (mode),
        .cnt         (cnt),
        .width       (width)
    );

    sr_ls_gate #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .TICK_W      (TICK_W)
    ) u_gate (
        .mode    (mode),
        .tick_cur(tick_cur),
        .width   (width),
        .seen_cur(seen_cur),
        .hs_drive(hs_drive),
        .ls_en   (ls_en)
    );
endmodule

// File: rtl/sr_rampin_chk.sv
module sr_rampin_chk
    import sr_rampin_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 32,
    parameter int unsigned RAMP_CYCLES  = 128,
    parameter int unsigned TICK_W       = $clog2(PERIOD_TICKS + 1),
    parameter int unsigned CNT_W        = $clog2(RAMP_CYCLES)
) (
    input logic              clk,
    input logic              rst,
    input logic              ss_active,
    input logic              period_start,
    input logic              hs_drive,
    input logic              ls_en,
    input ramp_mode_e        mode,
    input logic [CNT_W-1:0]  cnt,
    input logic [TICK_W-1:0] width,
    input logic              seen_run
);
    localparam int unsigned      STEP     = ceil_div(PERIOD_TICKS, RAMP_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RAMP_CYCLES - 1);

    logic              ss_prev;
    logic              ss_edge;
    logic [TICK_W-1:0] exp_grow;

    always_ff @(posedge clk) begin
        if (rst) ss_prev <= 1'b0;
        else     ss_prev <= ss_active;
    end

    assign ss_edge = ss_active & ~ss_prev;

    always_comb begin
        if (32'(width) + STEP >= PERIOD_TICKS)
            exp_grow = TICK_W'(PERIOD_TICKS);
        else
            exp_grow = TICK_W'(32'(width) + STEP);
    end

    p_reset_wait_r1: assert property (@(posedge clk)
        rst |=> (mode == MODE_WAIT) && !ls_en);

    p_wait_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WAIT) |-> !ls_en);

    p_width_grow_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RAMP && period_start && seen_run && cnt != CNT_LAST && !ss_edge)
        |=> width == $past(exp_grow));

    p_width_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RAMP && period_start && !seen_run && !ss_edge) |=> $stable(width));

    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RAMP && !period_start && !ss_edge)
        |=> $stable(cnt) && (mode == MODE_RAMP));

    p_full_comp_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FULL) |-> (ls_en != hs_drive));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        ls_en |-> !hs_drive);

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        ss_edge |=> (mode == MODE_WAIT) && (cnt == '0));
endmodule

bind sr_rampin sr_rampin_chk #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .RAMP_CYCLES (RAMP_CYCLES),
    .TICK_W      (TICK_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ss_active   (ss_active),
    .period_start(period_start),
    .hs_drive    (hs_drive),
    .ls_en       (ls_en),
    .mode        (mode),
    .cnt         (cnt),
    .width       (width),
    .seen_run    (seen_run)
);

// File: tb/sim_sr_rampin.sv
`timescale 1ns/1ps
module sim_sr_rampin;
    localparam int N    = 32;
    localparam int R    = 128;
    localparam int STEP = (N + R - 1) / R;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ss_active = 1'b0;
    logic period_start = 1'b0;
    logic hs_drive = 1'b0;
    logic ls_en;

    int n_checks = 0;
    int n_err = 0;

    // period-level model: 0 waiting, 1 ramp, 2 full
    int  m_mode = 0;
    int  m_w = 1;
    int  m_cnt = 0;
    bit  m_pend = 0;
    int  m_last_h = 0;
    bit  m_restarted = 0;

    always #2.5 clk = ~clk;

    sr_rampin #(.PERIOD_TICKS(N), .RAMP_CYCLES(R)) u0 (
        .clk(clk), .rst(rst), .ss_active(ss_active),
        .period_start(period_start), .hs_drive(hs_drive), .ls_en(ls_en)
    );

    task automatic chk(input string tag, input int act, input int exp, input int p, input int t);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s period %0d tick %0d actual=%0d expected=%0d", tag, p, t, act, exp);
        end
    endtask

    task automatic run_period(input int p, input int h, input logic ss_val, input bit restart);
        int  on_cnt = 0;
        bit  first = 0;
        int  exp;
        string tag;
        // tick 0: state from before this boundary
        @(posedge clk); #1;
        period_start = 1'b1; hs_drive = (h > 0); ss_active = ss_val;
        @(negedge clk);
        exp = (m_mode == 2) ? int'(h == 0) : 0;
        chk((m_mode == 2) ? "R7" : "R5", int'(ls_en), exp, p, 0);
        chk("R8", int'(ls_en && hs_drive), 0, p, 0);
        if (restart) begin
            m_mode = 0; m_pend = 0; m_restarted = 1;
        end else if (m_pend) begin
            if (m_cnt == R - 1) m_mode = 2;
            else begin
                m_cnt++;
                if (m_last_h > 0) m_w = (m_w + STEP >= N) ? N : m_w + STEP;
            end
            m_pend = 0;
        end
        if (m_mode == 0 && h > 0) begin
            m_mode = 1; m_w = 1; m_cnt = 0; first = 1; m_restarted = 0;
        end
        for (int t = 1; t < N; t++) begin
            @(posedge clk); #1;
            period_start = 1'b0; hs_drive = (t < h);
            @(negedge clk);
            if (m_mode == 0) begin
                exp = 0; tag = m_restarted ? "R9" : "R2";
            end else if (m_mode == 1) begin
                exp = int'(h > 0 && t >= h && t >= N - m_w);
                tag = (h == 0) ? "R6" : (first ? "R3" : "R5");
            end else begin
                exp = int'(t >= h); tag = "R7";
            end
            chk(tag, int'(ls_en), exp, p, t);
            chk("R8", int'(ls_en && hs_drive), 0, p, t);
            if (ls_en) on_cnt++;
        end
        if (m_mode == 1) begin
            if (h > 0) chk("R4", on_cnt, (m_w < N - h) ? m_w : N - h, p, -1);
            m_pend = 1; m_last_h = h;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int p = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(ls_en), 0, -1, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(ls_en), 0, -1, 0);
        // soft start, waiting periods without pulses (R2)
        for (int k = 0; k < 3; k++) begin run_period(p, 0, 1'b1, 0); p++; end
        // ramp with skipped periods, then full mode (R3..R8)
        for (int k = 0; k < 143; k++) begin
            run_period(p, (k % 9 == 4) ? 0 : 6 + (k % 11), 1'b1, 0); p++;
        end
        // restart out of full mode (R9)
        run_period(p, 10, 1'b0, 0); p++;
        run_period(p, 0, 1'b1, 1); p++;
        run_period(p, 0, 1'b1, 0); p++;
        // wide high-side pulse: on-time capped by off-time (R4, R5)
        for (int k = 0; k < 40; k++) begin
            run_period(p, (k == 5) ? 0 : 28, 1'b1, 0); p++;
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule